// File: doc/BRIEF.md
# Double-Buffered Backlight Dimming PWM

This block drives a single backlight dimming line from a small register window. The input clock first passes through a prescaler with a programmable divide ratio. Each prescaler tick then advances a period counter. The output is high while the period counter sits below the programmed high width, so the duty is set in whole prescaler ticks.

Software stages the divider, period and high width in shadow registers. A rising edge on the commit bit arms a transfer into the active set. The transfer lands on the next period boundary while the generator runs, or on the next cycle while it is stopped, so no period is ever cut short and no half-written setting reaches the pin. A manual mode bypasses the shadowing: the staged values drive the generator directly. It needs two controls set together, a select bit in the divider register and a two-bit override field in a separate register.

The high-width field is one bit wider than the period field. A width of zero therefore gives a dark output, and any width above the period count gives a fully-on output. The register interface is a plain synchronous bus with a valid strobe, a write flag, a byte address and 32-bit data. Read data is registered.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset the output is low and every mapped register reads back zero.
- R2: Every field reads back the value last written to it. Reserved bits and unmapped offsets read zero. The fields are: run enable at offset 0x00 bit 0; commit at 0x08 bit 0; divider at 0x10 bits 16 upward (DIV_W bits); manual select at 0x10 bit 1; period at 0x14 bits 0 upward (PER_W bits); high width at 0x14 bits 16 upward (HI_W bits); override pair at 0x80 bits 1:0.
- R3: While running with active divider d and period p, the output repeats every (d+1)*(p+1) input clocks.
- R4: Within each period, the output is high for exactly the first (d+1)*h clocks, where h is the active high width. h=0 gives a constant low. h>p gives a constant high.
- R5: While the run bit is 0, the output is low and the prescaler and period counter are held at zero. Setting the run bit starts the output at the first cycle of a period.
- R6: Writes to the divider or period/width registers do not change the output until they are committed, unless manual mode is on.
- R7: Only a 0-to-1 change of the commit bit arms a transfer. While running, the transfer takes effect at the next period boundary. While stopped, it takes effect on the following cycle.
- R8: Manual mode is on only when the select bit (0x10 bit 1) is 1 and the override pair (0x80 bits 1:0) is 11. In manual mode the staged values drive the generator directly. With either control alone, the committed values stay in force.
- R9: A read returns its data on bus_rdata one cycle after the request, and the value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Dimming output |

## Verification
The bench builds the block with a 2-bit divider, a 3-bit period and a 4-bit high width. This brings every divider and period value within reach, along with every high width from zero to two above the period. It checks all of these cycle by cycle against the arithmetic waveform over two full periods. The small widths also keep the commit-at-boundary, manual-mode and restart cases short enough to trace sample by sample.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam logic [7:0] OFS_RUN   = 8'h00;
  localparam logic [7:0] OFS_LATCH = 8'h08;
  localparam logic [7:0] OFS_DIV   = 8'h10;
  localparam logic [7:0] OFS_SHAPE = 8'h14;
  localparam logic [7:0] OFS_OVR   = 8'h80;
  localparam int DIV_LSB  = 16;
  localparam int HI_LSB   = 16;
  localparam int MODE_BIT = 1;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             boundary,
  output logic             run,
  output logic [DIV_W-1:0] eff_div,
  output logic [PER_W-1:0] eff_per,
  output logic [HI_W-1:0]  eff_hi
);
  import bl_pwm_pkg::*;

  logic             run_q, run_d, cmt_q, cmt_d, sel_q, sel_d, pend_q, pend_d;
  logic [1:0]       ovr_q, ovr_d;
  logic [DIV_W-1:0] sdiv_q, sdiv_d, adiv_q, adiv_d;
  logic [PER_W-1:0] sper_q, sper_d, aper_q, aper_d;
  logic [HI_W-1:0]  shi_q, shi_d, ahi_q, ahi_d;
  logic [31:0]      rdata_q, rdata_d;
  logic             wr, rd, cmt_rise, manual, apply;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr       = bus_valid && bus_write;
  assign rd       = bus_valid && !bus_write;
  assign cmt_rise = wr && (bus_addr == OFS_LATCH) && bus_wdata[0] && !cmt_q;
  assign manual   = sel_q && (ovr_q == 2'b11);
  assign apply    = pend_q && (!run_q || boundary);

  always_comb begin
    run_d  = run_q;
    cmt_d  = cmt_q;
    sel_d  = sel_q;
    ovr_d  = ovr_q;
    sdiv_d = sdiv_q;
    sper_d = sper_q;
    shi_d  = shi_q;
    if (wr) begin
      case (bus_addr)
        OFS_RUN:   run_d = bus_wdata[0];
        OFS_LATCH: cmt_d = bus_wdata[0];
        OFS_DIV: begin
          sel_d  = bus_wdata[MODE_BIT];
          sdiv_d = bus_wdata[DIV_LSB +: DIV_W];
        end
        OFS_SHAPE: begin
          sper_d = bus_wdata[PER_W-1:0];
          shi_d  = bus_wdata[HI_LSB +: HI_W];
        end
        OFS_OVR:   ovr_d = bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    pend_d = manual ? 1'b0 : ((pend_q && !apply) || cmt_rise);
    adiv_d = apply ? sdiv_q : adiv_q;
    aper_d = apply ? sper_q : aper_q;
    ahi_d  = apply ? shi_q  : ahi_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd) begin
      rdata_d = '0;
      case (bus_addr)
        OFS_RUN:   rdata_d[0] = run_q;
        OFS_LATCH: rdata_d[0] = cmt_q;
        OFS_DIV: begin
          rdata_d[MODE_BIT]          = sel_q;
          rdata_d[DIV_LSB +: DIV_W] = sdiv_q;
        end
        OFS_SHAPE: begin
          rdata_d[PER_W-1:0]       = sper_q;
          rdata_d[HI_LSB +: HI_W]  = shi_q;
        end
        OFS_OVR:   rdata_d[1:0] = ovr_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; cmt_q <= 1'b0; sel_q <= 1'b0; pend_q <= 1'b0;
      ovr_q <= '0; sdiv_q <= '0; sper_q <= '0; shi_q <= '0;
      adiv_q <= '0; aper_q <= '0; ahi_q <= '0; rdata_q <= '0;
    end else begin
      run_q <= run_d; cmt_q <= cmt_d; sel_q <= sel_d; pend_q <= pend_d;
      ovr_q <= ovr_d; sdiv_q <= sdiv_d; sper_q <= sper_d; shi_q <= shi_d;
      adiv_q <= adiv_d; aper_q <= aper_d; ahi_q <= ahi_d; rdata_q <= rdata_d;
    end
  end

  assign run       = run_q;
  assign eff_div   = manual ? sdiv_q : adiv_q;
  assign eff_per   = manual ? sper_q : aper_q;
  assign eff_hi    = manual ? shi_q  : ahi_q;
  assign bus_rdata = rdata_q;

  // R7: a fresh commit edge outside manual mode always leaves a transfer armed
  p_commit_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_rise && !manual) |=> pend_q);
  // R7: the active set only moves when a transfer was armed
  p_active_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({adiv_q, aper_q, ahi_q}) |-> $past(pend_q));
  // R7: while stopped an armed transfer completes on the next cycle
  p_idle_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !run_q && !cmt_rise) |=> !pend_q);
  // R9: read data holds when no read is requested
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: rtl/bl_pwm_timebase.sv
module bl_pwm_timebase #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] lim_div,
  input  logic [PER_W-1:0] lim_per,
  output logic [PER_W-1:0] cnt,
  output logic             boundary
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             tick, last;

  assign tick     = pre_q >= lim_div;
  assign last     = cnt_q >= lim_per;
  assign boundary = run && tick && last;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (!run) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = last ? '0 : cnt_q + PER_W'(1);
    end else begin
      pre_d = pre_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R5: a stopped generator sits at the start of a period
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && cnt_q == '0));
  // R3: the period counter wraps after the last tick of a period
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt_q == '0));
  // R3: the period counter only moves on a prescaler tick
  p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/bl_pwm_compare.sv
module bl_pwm_compare #(
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic             run,
  input  logic [PER_W-1:0] cnt,
  input  logic [HI_W-1:0]  hi,
  output logic             level
);
  localparam int CW = (PER_W > HI_W) ? PER_W : HI_W;
  logic [CW-1:0] cnt_x, hi_x;

  assign cnt_x = CW'(cnt);
  assign hi_x  = CW'(hi);
  assign level = run && (cnt_x < hi_x);
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);
  logic [1:0]       rst_sync;
  logic             core_rst_n, run, boundary;
  logic [DIV_W-1:0] eff_div;
  logic [PER_W-1:0] eff_per, cnt;
  logic [HI_W-1:0]  eff_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  bl_pwm_regs #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .boundary(boundary), .run(run), .eff_div(eff_div), .eff_per(eff_per),
    .eff_hi(eff_hi));

  bl_pwm_timebase #(.DIV_W(DIV_W), .PER_W(PER_W)) u_tb (
    .clk(clk), .rst_n(core_rst_n), .run(run), .lim_div(eff_div),
    .lim_per(eff_per), .cnt(cnt), .boundary(boundary));

  bl_pwm_compare #(.PER_W(PER_W), .HI_W(HI_W)) u_cmp (
    .run(run), .cnt(cnt), .hi(eff_hi), .level(pwm_out));

  // R4: zero width keeps the line dark
  p_zero_width_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (run && eff_hi == '0) |-> !pwm_out);
  // R4: a width past the period count keeps the line lit
  p_full_on_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (run && 32'(eff_hi) > 32'(eff_per)) |-> pwm_out);
  // R5: stopped means dark
  p_dark_idle_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    !run |-> !pwm_out);
endmodule

// File: tb/test_bl_pwm_top.sv
`timescale 1ns/1ps
module test_bl_pwm_top;
  localparam int DW = 2, PW = 3, HW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic pwm_out;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  bl_pwm_top #(.DIV_W(DW), .PER_W(PW), .HI_W(HW)) i_bl_pwm_top (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", "cycles", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic bit exp_lvl(int k, int d, int p, int h);
    return ((k / (d + 1)) % (p + 1)) < h;
  endfunction

  // Disable, stage and commit a configuration; output stays stopped.
  task automatic load_cfg(input int d, input int p, input int h);
    bus_wr(8'h00, 32'd0);
    bus_wr(8'h10, 32'(d) << 16);
    bus_wr(8'h14, (32'(h) << 16) | 32'(p));
    bus_wr(8'h08, 32'd1);
    bus_wr(8'h08, 32'd0);
  endtask

  // Enable, then compare n samples. Samples before k_sw expect width ha,
  // later ones hb. A commit write is issued after sample kc (kc<0: none).
  task automatic trace(input int n, input int d, input int p, input int ha,
                       input int hb, input int k_sw, input int kc,
                       input string tag_a, input string tag_b);
    int err_a = 0, err_b = 0;
    bus_wr(8'h00, 32'd1);
    for (int k = 0; k < n; k++) begin
      if (k < k_sw) begin
        if (pwm_out !== exp_lvl(k, d, p, ha)) err_a++;
      end else begin
        if (pwm_out !== exp_lvl(k, d, p, hb)) err_b++;
      end
      if (k == kc) bus_wr(8'h08, 32'd1);
      else @(negedge clk);
    end
    check(err_a == 0, tag_a, $sformatf("wave d=%0d p=%0d h=%0d mismatches", d, p, ha), err_a, 0);
    if (k_sw < n)
      check(err_b == 0, tag_b, $sformatf("wave after switch h=%0d mismatches", hb), err_b, 0);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(pwm_out == 1'b0, "R1", "pwm_out after reset", pwm_out, 0);
    foreach (rv[i]) ;
    begin
      logic [7:0] ofs [5] = '{8'h00, 8'h08, 8'h10, 8'h14, 8'h80};
      foreach (ofs[i]) begin
        bus_rd(ofs[i], rv);
        check(rv == 0, "R1", $sformatf("reg 0x%0h after reset", ofs[i]), rv, 0);
      end
    end

    // R2 readback of every field, reserved bits and unmapped offsets
    bus_wr(8'h10, 32'hFFFF_FFFF); bus_rd(8'h10, rv);
    check(rv == 32'h0003_0002, "R2", "divider reg all-ones", rv, 32'h0003_0002);
    bus_wr(8'h10, 32'h0002_0000); bus_rd(8'h10, rv);
    check(rv == 32'h0002_0000, "R2", "divider reg pattern", rv, 32'h0002_0000);
    bus_wr(8'h14, 32'hFFFF_FFFF); bus_rd(8'h14, rv);
    check(rv == 32'h000F_0007, "R2", "shape reg all-ones", rv, 32'h000F_0007);
    bus_wr(8'h14, 32'h0009_0005); bus_rd(8'h14, rv);
    check(rv == 32'h0009_0005, "R2", "shape reg pattern", rv, 32'h0009_0005);
    bus_wr(8'h80, 32'hFFFF_FFFE); bus_rd(8'h80, rv);
    check(rv == 32'h2, "R2", "override reg", rv, 2);
    bus_wr(8'h80, 32'h0);
    bus_wr(8'h08, 32'hFFFF_FFFF); bus_rd(8'h08, rv);
    check(rv == 32'h1, "R2", "commit reg", rv, 1);
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h00, 32'hFFFF_FFFF); bus_rd(8'h00, rv);
    check(rv == 32'h1, "R2", "run reg", rv, 1);
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h04, 32'hFFFF_FFFF); bus_rd(8'h04, rv);
    check(rv == 32'h0, "R2", "unmapped 0x04", rv, 0);
    bus_rd(8'h7C, rv);
    check(rv == 32'h0, "R2", "unmapped 0x7C", rv, 0);

    // R9 registered read data holds across non-read traffic
    bus_rd(8'h14, rv);
    bus_wr(8'h14, 32'h0001_0001);
    @(negedge clk);
    check(bus_rdata == 32'h0009_0005, "R9", "rdata held after write", bus_rdata, 32'h0009_0005);

    // R3/R4/R5 sweep over all dividers, periods and widths 0..p+2
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 8; p++)
        for (int h = 0; h <= p + 2; h++) begin
          load_cfg(d, p, h);
          trace(2 * (d + 1) * (p + 1), d, p, h, h, 1 << 30, -1, "R3/R4/R5", "R3");
        end

    // R5 stopping mid-run darkens the line
    load_cfg(1, 3, 7);
    bus_wr(8'h00, 32'd1);
    repeat (3) @(negedge clk);
    bus_wr(8'h00, 32'd0);
    begin
      int lit = 0;
      for (int k = 0; k < 6; k++) begin
        if (pwm_out) lit++;
        @(negedge clk);
      end
      check(lit == 0, "R5", "lit samples while stopped", lit, 0);
    end

    // R6/R7 staged width ignored until commit; commit lands on boundary
    load_cfg(1, 3, 1);
    bus_wr(8'h14, (32'd6 << 16) | 32'd3);
    bus_wr(8'h08, 32'd0);
    trace(32, 1, 3, 1, 6, 16, 10, "R6", "R7");
    bus_wr(8'h08, 32'd0);

    // R7 re-writing a commit bit already at 1 arms nothing
    load_cfg(0, 5, 2);
    bus_wr(8'h08, 32'd1);
    bus_wr(8'h08, 32'd0);
    bus_wr(8'h08, 32'd1);
    bus_wr(8'h14, (32'd5 << 16) | 32'd5);
    bus_wr(8'h08, 32'd1);
    repeat (2) @(negedge clk);
    trace(12, 0, 5, 2, 2, 1 << 30, -1, "R7", "R7");
    bus_wr(8'h08, 32'd0);

    // R8 override pair alone leaves committed values in force
    load_cfg(0, 7, 3);
    bus_wr(8'h80, 32'd3);
    bus_wr(8'h14, (32'd6 << 16) | 32'd7);
    trace(16, 0, 7, 3, 3, 1 << 30, -1, "R8", "R8");
    // R8 select bit alone also leaves committed values in force
    bus_wr(8'h00, 32'd0);
    bus_wr(8'h80, 32'd0);
    bus_wr(8'h10, 32'd2);
    trace(16, 0, 7, 3, 3, 1 << 30, -1, "R8", "R8");
    // R8 both set: staged values drive directly, no commit
    bus_wr(8'h00, 32'd0);
    bus_wr(8'h80, 32'd3);
    bus_wr(8'h10, (32'd1 << 16) | 32'd2);
    bus_wr(8'h14, (32'd2 << 16) | 32'd4);
    trace(20, 1, 4, 2, 2, 1 << 30, -1, "R8", "R8");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule